// File: doc/BRIEF.md
# Double-Buffered Nine-Bit Serial Transmitter

This block is the transmit half of an asynchronous serial port. Each frame carries one low start bit, eight data bits sent least-significant first, a ninth bit that the processor supplies, and one high stop bit. The line advances one bit on each pulse of an external bit-rate tick. A one-word holding buffer sits in front of the frame shifter. Software can therefore queue the next word while the current frame is still on the line.

Software loads the ninth bit first and then writes the data byte. The byte write copies both into the holding buffer as one word. A status output shows that the buffer is occupied, and a data write made while it is occupied is dropped.

Two mode inputs decide where the transmit interrupt is raised. One input places it at the start or at the end of the stop bit. The other input decides whether a frame with nothing queued behind it still raises an interrupt. The interrupt flag stays set until software clears it. If a word is written during the stop bit of what looked like the last frame, the block resolves the race on a single clock edge, so each frame raises exactly one stop-bit interrupt.

Top module: `ninebit_dbuf_tx`

## Requirements
- R1: After reset, tx_line is 1, tx_irq is 0 and buf_full is 0.
- R2: With the shifter idle and the buffer empty, a data write sampled at edge W sets buf_full after W. At edge W+1 the frame begins: tx_line goes low, tx_irq is set and buf_full clears.
- R3: A frame is, in order: start bit 0, data bits 0 through 7, the ninth bit, and stop bit 1. Each bit ends on a clock edge at which bit_tick is 1.
- R4: The ninth bit sent is the value held by the ninth-bit register at the data write. A ninth-bit write after that data write does not change the frame.
- R5: A data write while buf_full is 1 is dropped. buf_full stays 1, and the dropped byte is never sent.
- R6: With irq_late = 0 and a word queued, tx_irq is set on the edge that ends the ninth bit (stop start), and buf_full clears on that edge. The queued frame starts on the edge that ends the stop bit, with no idle bit in between.
- R7: With irq_late = 1 and a word queued, tx_irq is not set at stop start. It is set on the edge that ends the stop bit, and the queued frame starts on that same edge.
- R8: With last_irq_en = 0 and nothing queued, no interrupt is raised at either end of the final stop bit, and tx_line stays 1 afterwards.
- R9: With last_irq_en = 1, irq_late = 0 and nothing queued, tx_irq is set at the start of the final stop bit.
- R10: With last_irq_en = 1, irq_late = 1 and nothing queued, tx_irq is set at the end of the final stop bit.
- R11: With irq_late = 0 and last_irq_en = 1, a word written during the final stop bit after its start-of-stop interrupt starts at the end of that stop bit. No second interrupt is raised there, so each frame gets one stop-bit interrupt.
- R12: tx_irq stays set until irq_clr is 1 at an edge. If the flag is set and cleared on the same edge, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| ninth_wr | input | 1 | Write strobe for the ninth-bit register |
| ninth_in | input | 1 | Ninth-bit value |
| data_wr | input | 1 | Write strobe for the data byte |
| data_in | input | DATA_W | Data byte |
| irq_late | input | 1 | 0: interrupt at stop start, 1: at stop end |
| last_irq_en | input | 1 | Raise an interrupt for a frame with nothing queued |
| irq_clr | input | 1 | Clears tx_irq |
| tx_line | output | 1 | Serial output, idle high |
| tx_irq | output | 1 | Transmit interrupt flag |
| buf_full | output | 1 | Holding buffer occupied |

## Verification
A data write sampled at edge W shows on buf_full one cycle later. The frame start and its interrupt show after edge W+1. A stop-start interrupt appears right after the edge that ends the ninth bit, and a stop-end interrupt right after the edge that ends the stop bit. The monitor reads each serial bit on the falling edge before the bit_tick edge that ends it. It then checks tx_irq on the falling edge just after the frame-start edge, the stop-start edge and the stop-end edge. Each check is compared against the expected word and interrupt placement that the driver queued.

// File: rtl/ntx_pkg.sv
// Shared types for the nine-bit transmitter.
// Assumes nothing beyond being compiled before the modules that import it.
package ntx_pkg;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_t;

endpackage

// File: rtl/ntx_hold_buf.sv
// Holding buffer: keeps the ninth-bit register and one queued word.
// Assumes the ninth bit is written before its data byte; take is only
// pulsed by the sequencer while full is set.
module ntx_hold_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ninth_wr,
    input  logic              ninth_in,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              take,
    output logic              full,
    output logic [DATA_W:0]   word
);

    logic ninth_q;

    // Ninth-bit register, loaded ahead of the byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ninth_q <= 1'b0;
        else if (ninth_wr)
            ninth_q <= ninth_in;
    end

    // Queue slot: accepts a byte only when empty, frees on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            word <= '0;
        end else if (!full && data_wr) begin
            full <= 1'b1;
            word <= {ninth_q, data_in};
        end else if (take) begin
            full <= 1'b0;
        end
    end

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && data_wr) |=> full); // R2
    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (full && data_wr && !take) |=> (full && $stable(word))); // R5
    AST_TAKE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full); // R6

endmodule

// File: rtl/ntx_frame_seq.sv
// Frame sequencer: shifts start, data, ninth and stop bits onto the line,
// pulls words from the holding buffer and decides each interrupt event.
// Assumes bit_tick is a single-cycle pulse and the mode inputs change
// only while the line is idle.
module ntx_frame_seq
    import ntx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_tick,
    input  logic            irq_late,
    input  logic            last_irq_en,
    input  logic            buf_full,
    input  logic [DATA_W:0] hold_word,
    output logic            take,
    output logic            irq_set,
    output logic            busy,
    output logic            tx_line
);

    localparam int FRAME_LEN = DATA_W + 3;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] NINTH_I = IDX_W'(DATA_W + 1);
    localparam logic [IDX_W-1:0] STOP_I  = IDX_W'(DATA_W + 2);

    seq_state_t       state;
    logic [IDX_W-1:0] idx;
    logic [DATA_W:0]  sreg;
    logic             pending;
    logic             irq_given;

    logic tick_run, at_sos, at_eos, idle_load;
    logic early_xfer, eos_xfer, sos_irq, eos_irq;

    assign busy = (state == SQ_RUN);

    // Event decode: which frame boundary this cycle's tick closes.
    always_comb begin
        tick_run   = busy && bit_tick;
        at_sos     = tick_run && (idx == NINTH_I);
        at_eos     = tick_run && (idx == STOP_I);
        idle_load  = !busy && buf_full;
        early_xfer = at_sos && !irq_late && buf_full;
        eos_xfer   = at_eos && buf_full && !pending;
    end

    // Interrupt placement: one stop-bit event per frame, buffer sampled here.
    always_comb begin
        sos_irq = at_sos && !irq_late && (buf_full || last_irq_en);
        if (irq_late)
            eos_irq = at_eos && (buf_full || last_irq_en);
        else
            eos_irq = eos_xfer && !irq_given;
        irq_set = idle_load || sos_irq || eos_irq;
        take    = idle_load || early_xfer || eos_xfer;
    end

    // Frame state, bit index and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            idx       <= '0;
            sreg      <= '0;
            pending   <= 1'b0;
            irq_given <= 1'b0;
        end else if (idle_load) begin
            state     <= SQ_RUN;
            idx       <= '0;
            sreg      <= hold_word;
            pending   <= 1'b0;
            irq_given <= 1'b0;
        end else if (tick_run) begin
            if (at_eos) begin
                if (pending) begin
                    idx       <= '0;
                    pending   <= 1'b0;
                    irq_given <= 1'b0;
                end else if (buf_full) begin
                    idx       <= '0;
                    sreg      <= hold_word;
                    irq_given <= 1'b0;
                end else begin
                    state <= SQ_IDLE;
                end
            end else begin
                idx <= idx + 1'b1;
                if ((idx != '0) && (idx < NINTH_I))
                    sreg <= sreg >> 1;
                if (at_sos) begin
                    irq_given <= sos_irq;
                    if (early_xfer) begin
                        sreg    <= hold_word;
                        pending <= 1'b1;
                    end
                end
            end
        end
    end

    // Line level from the frame position.
    always_comb begin
        if (!busy)
            tx_line = 1'b1;
        else if (idx == '0)
            tx_line = 1'b0;
        else if (idx == STOP_I)
            tx_line = 1'b1;
        else
            tx_line = sreg[0];
    end

    AST_LOAD_BEGINS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && buf_full) |=> (busy && !tx_line)); // R2
    AST_LATE_SKIPS_SOS: assert property (@(posedge clk) disable iff (!rst_n)
        (at_sos && irq_late) |-> !irq_set); // R7
    AST_PENDING_START_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (at_eos && pending) |-> !irq_set); // R11
    AST_LAST_FRAME_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        (at_eos && !buf_full && !pending) |=> (tx_line && !busy)); // R8

endmodule

// File: rtl/ntx_irq_flag.sv
// Interrupt flag: set by the sequencer, cleared by software.
// Assumes set and clear may coincide; set takes priority.
module ntx_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_set,
    input  logic irq_clr,
    output logic tx_irq
);

    // Sticky flag with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_irq <= 1'b0;
        else if (irq_set)
            tx_irq <= 1'b1;
        else if (irq_clr)
            tx_irq <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> tx_irq); // R12
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !irq_set) |=> !tx_irq); // R12

endmodule

// File: rtl/ninebit_dbuf_tx.sv
// Top of the double-buffered nine-bit transmitter: ties the holding buffer,
// the frame sequencer and the interrupt flag together.
// Assumes bit_tick comes from an external bit-rate divider.
module ninebit_dbuf_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              ninth_wr,
    input  logic              ninth_in,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              irq_late,
    input  logic              last_irq_en,
    input  logic              irq_clr,
    output logic              tx_line,
    output logic              tx_irq,
    output logic              buf_full
);

    logic            take;
    logic            irq_set;
    logic            busy;
    logic [DATA_W:0] hold_word;

    ntx_hold_buf #(.DATA_W(DATA_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ninth_wr (ninth_wr),
        .ninth_in (ninth_in),
        .data_wr  (data_wr),
        .data_in  (data_in),
        .take     (take),
        .full     (buf_full),
        .word     (hold_word)
    );

    ntx_frame_seq #(.DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .irq_late    (irq_late),
        .last_irq_en (last_irq_en),
        .buf_full    (buf_full),
        .hold_word   (hold_word),
        .take        (take),
        .irq_set     (irq_set),
        .busy        (busy),
        .tx_line     (tx_line)
    );

    ntx_irq_flag u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_set (irq_set),
        .irq_clr (irq_clr),
        .tx_irq  (tx_irq)
    );

    AST_BUF_FREED_BY_SHIFTER: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && take) |=> (busy && !buf_full)); // R6

endmodule

// File: tb/ninebit_dbuf_tx_tb_top.sv
// Scoreboard bench: the driver queues expected frames, the monitor
// decodes the line and the interrupt flag and compares.
module ninebit_dbuf_tx_tb_top;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_tick = 1'b0;
    logic          ninth_wr = 1'b0;
    logic          ninth_in = 1'b0;
    logic          data_wr = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic          irq_late = 1'b0;
    logic          last_irq_en = 1'b0;
    logic          auto_en = 1'b1;
    logic          auto_pulse = 1'b0;
    logic          man_clr = 1'b0;
    logic          irq_clr;
    logic          tx_line, tx_irq, buf_full;

    assign irq_clr = auto_pulse | man_clr;

    always #2 clk = ~clk;

    ninebit_dbuf_tx #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .ninth_wr(ninth_wr), .ninth_in(ninth_in),
        .data_wr(data_wr), .data_in(data_in),
        .irq_late(irq_late), .last_irq_en(last_irq_en), .irq_clr(irq_clr),
        .tx_line(tx_line), .tx_irq(tx_irq), .buf_full(buf_full)
    );

    typedef struct packed {
        logic [DW:0] word;
        logic        ib;
        logic        is_s;
        logic        ie;
        logic [7:0]  req;
    } exp_t;

    exp_t   exp_q[$];
    exp_t   cur;
    int     n_chk = 0;
    int     n_err = 0;
    int     cyc = 0;
    int     tcnt = 0;
    int     nbit = 0;
    logic   mon_active = 1'b0;
    logic   in_frame = 1'b0;
    logic   prev_line = 1'b1;
    logic   chk_is = 1'b0;
    logic   chk_ie = 1'b0;
    logic [DW+2:0] rx = '0;
    event   sos_ev;

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // bit_tick: one cycle high in every four
    always @(negedge clk) begin
        tcnt = (tcnt + 1) % 4;
        bit_tick = (tcnt == 0);
    end

    // automatic interrupt acknowledge
    always @(negedge clk) auto_pulse = auto_en && tx_irq;

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            chk(1'b0, "watchdog", cyc, 0);
            finish_run();
        end
    end

    // monitor: decode frames, check interrupt placement
    always @(negedge clk) begin
        if (rst_n) begin
            if (chk_is) begin
                chk(tx_irq == cur.is_s, $sformatf("R%0d stop-start irq", cur.req), tx_irq, cur.is_s);
                chk_is = 1'b0;
            end
            if (chk_ie) begin
                chk(tx_irq == cur.ie, $sformatf("R%0d stop-end irq", cur.req), tx_irq, cur.ie);
                chk_ie = 1'b0;
                mon_active = 1'b0;
            end
            if (!in_frame && prev_line && !tx_line) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected frame", 1, 0);
                    cur = '0;
                end else begin
                    cur = exp_q.pop_front();
                end
                chk(tx_irq == cur.ib, $sformatf("R%0d frame-start irq", cur.req), tx_irq, cur.ib);
                in_frame = 1'b1;
                mon_active = 1'b1;
                nbit = 0;
            end
            if (in_frame && bit_tick) begin
                rx[nbit] = tx_line;
                if (nbit == DW + 1) begin
                    chk_is = 1'b1;
                    -> sos_ev;
                end
                if (nbit == DW + 2) begin
                    chk(rx[0] == 1'b0 && rx[DW+2] == 1'b1, "R3 start/stop levels",
                        {rx[DW+2], rx[0]}, 2);
                    chk(rx[DW+1:1] == cur.word, $sformatf("R3 R4 word (R%0d)", cur.req),
                        rx[DW+1:1], cur.word);
                    in_frame = 1'b0;
                    chk_ie = 1'b1;
                end
                nbit++;
            end
            prev_line = tx_line;
        end
    end

    task automatic put_ninth(input logic b);
        @(negedge clk);
        ninth_wr = 1'b1;
        ninth_in = b;
        @(negedge clk);
        ninth_wr = 1'b0;
    endtask

    task automatic put_byte(input logic [DW-1:0] b);
        @(negedge clk);
        data_wr = 1'b1;
        data_in = b;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    task automatic expect_frame(input logic [DW:0] w, input logic ib, input logic is_s,
                                input logic ie, input int req);
        exp_t e;
        e.word = w; e.ib = ib; e.is_s = is_s; e.ie = ie; e.req = 8'(req);
        exp_q.push_back(e);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (exp_q.size() != 0 || mon_active) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_line == 1'b1, "R1 idle line", tx_line, 1);
        chk(tx_irq == 1'b0, "R1 irq clear", tx_irq, 0);
        chk(buf_full == 1'b0, "R1 buffer empty", buf_full, 0);

        // R2 / R4 / R8: single frame, no last-frame interrupt
        irq_late = 1'b0; last_irq_en = 1'b0;
        put_ninth(1'b1);
        expect_frame({1'b1, 8'hA5}, 1'b1, 1'b0, 1'b0, 8);
        put_byte(8'hA5);
        chk(buf_full == 1'b1, "R2 buffer fills after write", buf_full, 1);
        ninth_wr = 1'b1; ninth_in = 1'b0;
        @(negedge clk);
        ninth_wr = 1'b0;
        chk(buf_full == 1'b0, "R2 buffer freed at load", buf_full, 0);
        chk(tx_line == 1'b0, "R2 start bit at load", tx_line, 0);
        chk(tx_irq == 1'b1, "R2 irq at load", tx_irq, 1);
        wait_idle();
        chk(tx_line == 1'b1, "R8 line idle after last frame", tx_line, 1);
        chk(tx_irq == 1'b0, "R8 no trailing irq", tx_irq, 0);

        // R9: last-frame interrupt at stop start
        last_irq_en = 1'b1; irq_late = 1'b0;
        put_ninth(1'b0);
        expect_frame({1'b0, 8'h3C}, 1'b1, 1'b1, 1'b0, 9);
        put_byte(8'h3C);
        wait_idle();

        // R10: last-frame interrupt at stop end
        irq_late = 1'b1;
        put_ninth(1'b1);
        expect_frame({1'b1, 8'h0F}, 1'b1, 1'b0, 1'b1, 10);
        put_byte(8'h0F);
        wait_idle();

        // R6 / R5: queued word with early interrupt; third write dropped
        irq_late = 1'b0; last_irq_en = 1'b0;
        put_ninth(1'b1);
        expect_frame({1'b1, 8'hF1}, 1'b1, 1'b1, 1'b0, 6);
        put_byte(8'hF1);
        put_ninth(1'b0);
        expect_frame({1'b0, 8'h12}, 1'b0, 1'b0, 1'b0, 6);
        put_byte(8'h12);
        put_byte(8'h77);
        chk(buf_full == 1'b1, "R5 buffer still full", buf_full, 1);
        wait_idle();
        chk(exp_q.size() == 0, "R5 dropped byte not sent", exp_q.size(), 0);

        // R7: queued word with late interrupt
        irq_late = 1'b1; last_irq_en = 1'b1;
        put_ninth(1'b0);
        expect_frame({1'b0, 8'h5A}, 1'b1, 1'b0, 1'b1, 7);
        put_byte(8'h5A);
        put_ninth(1'b1);
        expect_frame({1'b1, 8'hC3}, 1'b1, 1'b0, 1'b1, 7);
        put_byte(8'hC3);
        wait_idle();

        // R11: write lands in the final stop bit
        irq_late = 1'b0; last_irq_en = 1'b1;
        put_ninth(1'b1);
        expect_frame({1'b1, 8'h81}, 1'b1, 1'b1, 1'b0, 11);
        put_byte(8'h81);
        @(sos_ev);
        put_ninth(1'b0);
        expect_frame({1'b0, 8'h7E}, 1'b0, 1'b1, 1'b0, 11);
        put_byte(8'h7E);
        wait_idle();

        // R12: flag holds until cleared; set beats clear
        irq_late = 1'b0; last_irq_en = 1'b0; auto_en = 1'b0;
        put_ninth(1'b0);
        expect_frame({1'b0, 8'h66}, 1'b1, 1'b0, 1'b0, 12);
        put_byte(8'h66);
        repeat (4) @(negedge clk);
        chk(tx_irq == 1'b1, "R12 flag held", tx_irq, 1);
        man_clr = 1'b1;
        @(negedge clk);
        man_clr = 1'b0;
        chk(tx_irq == 1'b0, "R12 flag cleared", tx_irq, 0);
        wait_idle();
        man_clr = 1'b1;
        put_ninth(1'b1);
        expect_frame({1'b1, 8'h99}, 1'b1, 1'b0, 1'b0, 12);
        put_byte(8'h99);
        @(negedge clk);
        chk(tx_irq == 1'b1, "R12 set wins over clear", tx_irq, 1);
        @(negedge clk);
        chk(tx_irq == 1'b0, "R12 clear after set", tx_irq, 0);
        wait_idle();
        man_clr = 1'b0; auto_en = 1'b1;

        chk(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);
        finish_run();
    end

endmodule